// File: doc/BRIEF.md
# Nested Stage Counter Unit

This block keeps the iteration counters for the nested stages of one program loop. Stage 1 is the outermost stage and each higher stage number sits one level deeper. Each stage keeps two values: the count it was loaded with and the count it is working down. A load command fills both values from one of four sources. These are the instruction length, the outer stage's loaded count, the outer stage's working count, or the constant one. Inner counters can therefore copy their outer stage, which is what triangular (diagonal) iteration needs.

A decrement command steps the addressed stage's working count down by one. It compares the count with zero either before or after the step. When the comparison hits, it writes a chosen value into one of seven flags. While a stage is in its exit segment, it can nudge the working count of the stage directly inside it up or down by one. It can also read back both values of that inner stage.

A start strobe clears every counter and flag at the start of each instruction. The sequencer that issues the commands is outside this block.

Top module: `nested_stage_counter`

## Requirements
- R1: Reset, or a `start_i` pulse, sets every stage's loaded and working counts to 0 and all seven flags to 0. `start_i` outranks every other command in the same cycle.
- R2: A load with source code 00 puts `len_i` into both the loaded and the working count of the addressed stage.
- R3: Source code 01 copies the loaded count of stage `stage_i`-1, and code 10 copies its working count. For stage 1, which has no outer stage, both codes take `len_i`.
- R4: Source code 11 loads the constant 1 into both counts.
- R5: A decrement with mode 00, or with the unused mode 01, leaves every counter and flag as they were.
- R6: Mode 10 compares the working count with zero first and then subtracts one. Counts wrap modulo 2^CNT_W, so 0 becomes all ones.
- R7: Mode 11 subtracts one first and then compares the new count with zero.
- R8: When the zero comparison hits, flag number `flag_sel_i` (1 to 7, driven on `flags_o` bit `flag_sel_i`-1) takes the value of `flag_val_i`. With `flag_sel_i` = 0, or with no hit, the flags keep their values. The count still changes in both cases.
- R9: With `exit_seg_i` high, `inc_inner_i` adds one to the working count of stage `stage_i`+1 and `dec_inner_i` subtracts one. Neither touches that stage's loaded count, and both at once do nothing.
- R10: Inner adjust commands are ignored when `exit_seg_i` is low, and also when `stage_i` is the deepest stage.
- R11: While `exit_seg_i` is high, `inner_cur_o` and `inner_init_o` show the working and loaded counts of stage `stage_i`+1. Otherwise they read 0.
- R12: Priority within a cycle is load, then decrement, then inner adjust. A `stage_i` of 0, or one above NUM_STAGES, executes nothing, and the stage outputs then read 0.
- R13: `cur_o` and `init_o` show the addressed stage's stored counts. A command's effect appears only after the rising edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Instruction start: clears counters and flags |
| len_i | input | CNT_W | Instruction length value |
| stage_i | input | STG_W | Addressed stage number, 1 is outermost |
| load_i | input | 1 | Load command |
| load_src_i | input | 2 | Load source code |
| dec_i | input | 1 | Decrement command |
| dec_mode_i | input | 2 | Decrement / zero-test ordering code |
| flag_sel_i | input | 3 | Flag number to write, 0 for none |
| flag_val_i | input | 1 | Value written to the selected flag |
| exit_seg_i | input | 1 | Addressed stage is in its exit segment |
| inc_inner_i | input | 1 | Increment the next inner stage's working count |
| dec_inner_i | input | 1 | Decrement the next inner stage's working count |
| cur_o | output | CNT_W | Working count of the addressed stage |
| init_o | output | CNT_W | Loaded count of the addressed stage |
| inner_cur_o | output | CNT_W | Working count of the next inner stage |
| inner_init_o | output | CNT_W | Loaded count of the next inner stage |
| flags_o | output | 7 | Flags 1..7 on bits 0..6 |

## Verification
Every command acts at the one rising edge that samples it, so its result is due one edge later. The read outputs are combinational from the stored counts and the present `stage_i`, so a readback is valid in the same cycle in which the stage is addressed. The driver applies each command just after a falling edge. After the following rising edge it switches the stage address to the stage it wants to see. It then queues the expected outputs, and the monitor compares them at the next falling edge. One extra check samples `cur_o` before the accepting edge, to confirm that no result shows early.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

  typedef enum logic [1:0] {
    SRC_LEN       = 2'b00,
    SRC_OUTER_INI = 2'b01,
    SRC_OUTER_CUR = 2'b10,
    SRC_ONE       = 2'b11
  } init_src_e;

  typedef enum logic [1:0] {
    DM_HOLD       = 2'b00,
    DM_SPARE      = 2'b01,
    DM_TEST_FIRST = 2'b10,
    DM_STEP_FIRST = 2'b11
  } dec_mode_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_CLEAR,
    OP_LOAD,
    OP_DEC,
    OP_ADJ_UP,
    OP_ADJ_DN
  } nsc_op_e;

endpackage

// File: rtl/nsc_cmd_decode.sv
module nsc_cmd_decode
  import nsc_pkg::*;
#(
  parameter int NUM_STAGES = 31,
  parameter int STG_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic             start_i,
  input  logic             load_i,
  input  logic             dec_i,
  input  logic             exit_seg_i,
  input  logic             inc_inner_i,
  input  logic             dec_inner_i,
  input  logic [STG_W-1:0] stage_i,
  output nsc_op_e          op_o,
  output logic             stage_ok_o,
  output logic             outer_ok_o,
  output logic             inner_ok_o,
  output logic [STG_W-1:0] idx_o,
  output logic [STG_W-1:0] outer_idx_o,
  output logic [STG_W-1:0] inner_idx_o
);

  localparam logic [STG_W-1:0] LAST_STAGE = STG_W'(NUM_STAGES);

  logic stage_ok;
  logic inner_ok;
  logic adj_one;

  assign stage_ok = (stage_i != '0) && (stage_i <= LAST_STAGE);
  assign inner_ok = stage_ok && (stage_i < LAST_STAGE);
  assign adj_one  = inc_inner_i ^ dec_inner_i;

  assign stage_ok_o  = stage_ok;
  assign inner_ok_o  = inner_ok;
  assign outer_ok_o  = stage_ok && (stage_i > STG_W'(1));
  assign idx_o       = stage_ok ? stage_i - STG_W'(1) : '0;
  assign outer_idx_o = outer_ok_o ? stage_i - STG_W'(2) : '0;
  assign inner_idx_o = inner_ok ? stage_i : '0;

  always_comb begin
    op_o = OP_NONE;
    if (start_i)                                 op_o = OP_CLEAR;
    else if (stage_ok && load_i)                 op_o = OP_LOAD;
    else if (stage_ok && dec_i)                  op_o = OP_DEC;
    else if (inner_ok && exit_seg_i && adj_one)  op_o = inc_inner_i ? OP_ADJ_UP : OP_ADJ_DN;
  end

endmodule

// File: rtl/nsc_stage_bank.sv
module nsc_stage_bank #(
  parameter int NUM_STAGES = 31,
  parameter int CNT_W      = 16,
  parameter int STG_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clr_i,
  input  logic [STG_W-1:0]                    wr_idx_i,
  input  logic                                cur_we_i,
  input  logic                                init_we_i,
  input  logic [CNT_W-1:0]                    wr_data_i,
  output logic [NUM_STAGES-1:0][CNT_W-1:0]    cur_o,
  output logic [NUM_STAGES-1:0][CNT_W-1:0]    init_o
);

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic hit;
    assign hit = (wr_idx_i == STG_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_o[g]  <= '0;
        init_o[g] <= '0;
      end else if (clr_i) begin
        cur_o[g]  <= '0;
        init_o[g] <= '0;
      end else begin
        if (cur_we_i && hit)  cur_o[g]  <= wr_data_i;
        if (init_we_i && hit) init_o[g] <= wr_data_i;
      end
    end
  end

endmodule

// File: rtl/nsc_flag_file.sv
module nsc_flag_file #(
  parameter int NUM_FLAGS = 7,
  parameter int SEL_W     = $clog2(NUM_FLAGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr_i,
  input  logic                 we_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 val_i,
  output logic [NUM_FLAGS-1:0] flags_o
);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   flags_o[g] <= 1'b0;
      else if (clr_i)                               flags_o[g] <= 1'b0;
      else if (we_i && (sel_i == SEL_W'(g + 1)))    flags_o[g] <= val_i;
    end
  end

endmodule

// File: rtl/nested_stage_counter.sv
module nested_stage_counter
  import nsc_pkg::*;
#(
  parameter int NUM_STAGES = 31,
  parameter int CNT_W      = 16,
  parameter int NUM_FLAGS  = 7,
  parameter int STG_W      = $clog2(NUM_STAGES + 1),
  parameter int FSEL_W     = $clog2(NUM_FLAGS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     len_i,
  input  logic [STG_W-1:0]     stage_i,
  input  logic                 load_i,
  input  logic [1:0]           load_src_i,
  input  logic                 dec_i,
  input  logic [1:0]           dec_mode_i,
  input  logic [FSEL_W-1:0]    flag_sel_i,
  input  logic                 flag_val_i,
  input  logic                 exit_seg_i,
  input  logic                 inc_inner_i,
  input  logic                 dec_inner_i,
  output logic [CNT_W-1:0]     cur_o,
  output logic [CNT_W-1:0]     init_o,
  output logic [CNT_W-1:0]     inner_cur_o,
  output logic [CNT_W-1:0]     inner_init_o,
  output logic [NUM_FLAGS-1:0] flags_o
);

  // Step result: MSB is the zero-test hit, the rest the next count.
  function automatic logic [CNT_W:0] count_step(input logic [1:0] mode,
                                                input logic [CNT_W-1:0] cnt);
    logic [CNT_W-1:0] less;
    less = cnt - CNT_W'(1);
    case (dec_mode_e'(mode))
      DM_TEST_FIRST: count_step = {(cnt == '0), less};
      DM_STEP_FIRST: count_step = {(less == '0), less};
      default:       count_step = {1'b0, cnt};
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] pick_init(input logic [1:0]       src,
                                                 input logic [CNT_W-1:0] len,
                                                 input logic [CNT_W-1:0] o_ini,
                                                 input logic [CNT_W-1:0] o_cur,
                                                 input logic             has_outer);
    case (init_src_e'(src))
      SRC_LEN:       pick_init = len;
      SRC_OUTER_INI: pick_init = has_outer ? o_ini : len;
      SRC_OUTER_CUR: pick_init = has_outer ? o_cur : len;
      default:       pick_init = CNT_W'(1);
    endcase
  endfunction

  nsc_op_e                          op;
  logic                             stage_ok, outer_ok, inner_ok;
  logic [STG_W-1:0]                 idx, outer_idx, inner_idx;
  logic [NUM_STAGES-1:0][CNT_W-1:0] cur_arr;
  logic [NUM_STAGES-1:0][CNT_W-1:0] init_arr;
  logic [CNT_W-1:0]                 sel_cur, sel_init;
  logic [CNT_W-1:0]                 out_cur, out_init;
  logic [CNT_W-1:0]                 in_cur, in_init;
  logic [CNT_W:0]                   step;

  // Named internal events, brought out for the checker.
  logic                             ev_clear, ev_load, ev_dec;
  logic                             ev_adj_up, ev_adj_dn, ev_flag_wr;
  logic                             dec_hit;
  logic [STG_W-1:0]                 wr_idx;
  logic [CNT_W-1:0]                 wr_data;
  logic                             cur_we, init_we;

  nsc_cmd_decode #(
    .NUM_STAGES (NUM_STAGES),
    .STG_W      (STG_W)
  ) u_decode (
    .start_i     (start_i),
    .load_i      (load_i),
    .dec_i       (dec_i),
    .exit_seg_i  (exit_seg_i),
    .inc_inner_i (inc_inner_i),
    .dec_inner_i (dec_inner_i),
    .stage_i     (stage_i),
    .op_o        (op),
    .stage_ok_o  (stage_ok),
    .outer_ok_o  (outer_ok),
    .inner_ok_o  (inner_ok),
    .idx_o       (idx),
    .outer_idx_o (outer_idx),
    .inner_idx_o (inner_idx)
  );

  assign sel_cur  = stage_ok ? cur_arr[idx]        : '0;
  assign sel_init = stage_ok ? init_arr[idx]       : '0;
  assign out_cur  = outer_ok ? cur_arr[outer_idx]  : '0;
  assign out_init = outer_ok ? init_arr[outer_idx] : '0;
  assign in_cur   = inner_ok ? cur_arr[inner_idx]  : '0;
  assign in_init  = inner_ok ? init_arr[inner_idx] : '0;

  assign step      = count_step(dec_mode_i, sel_cur);
  assign dec_hit   = step[CNT_W];

  assign ev_clear   = (op == OP_CLEAR);
  assign ev_load    = (op == OP_LOAD);
  assign ev_dec     = (op == OP_DEC);
  assign ev_adj_up  = (op == OP_ADJ_UP);
  assign ev_adj_dn  = (op == OP_ADJ_DN);
  assign ev_flag_wr = ev_dec && dec_hit && (flag_sel_i != '0);

  assign cur_we  = ev_load || ev_dec || ev_adj_up || ev_adj_dn;
  assign init_we = ev_load;
  assign wr_idx  = (ev_adj_up || ev_adj_dn) ? inner_idx : idx;

  always_comb begin
    wr_data = sel_cur;
    case (op)
      OP_LOAD:   wr_data = pick_init(load_src_i, len_i, out_init, out_cur, outer_ok);
      OP_DEC:    wr_data = step[CNT_W-1:0];
      OP_ADJ_UP: wr_data = in_cur + CNT_W'(1);
      OP_ADJ_DN: wr_data = in_cur - CNT_W'(1);
      default:   wr_data = sel_cur;
    endcase
  end

  nsc_stage_bank #(
    .NUM_STAGES (NUM_STAGES),
    .CNT_W      (CNT_W),
    .STG_W      (STG_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (ev_clear),
    .wr_idx_i  (wr_idx),
    .cur_we_i  (cur_we),
    .init_we_i (init_we),
    .wr_data_i (wr_data),
    .cur_o     (cur_arr),
    .init_o    (init_arr)
  );

  nsc_flag_file #(
    .NUM_FLAGS (NUM_FLAGS),
    .SEL_W     (FSEL_W)
  ) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (ev_clear),
    .we_i    (ev_flag_wr),
    .sel_i   (flag_sel_i),
    .val_i   (flag_val_i),
    .flags_o (flags_o)
  );

  assign cur_o        = sel_cur;
  assign init_o       = sel_init;
  assign inner_cur_o  = exit_seg_i ? in_cur  : '0;
  assign inner_init_o = exit_seg_i ? in_init : '0;

endmodule

// File: rtl/nsc_checker.sv
module nsc_checker #(
  parameter int NUM_STAGES = 31,
  parameter int CNT_W      = 16,
  parameter int NUM_FLAGS  = 7,
  parameter int STG_W      = 5,
  parameter int FSEL_W     = 3
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             start_i,
  input logic                             load_i,
  input logic                             dec_i,
  input logic [1:0]                       dec_mode_i,
  input logic [FSEL_W-1:0]                flag_sel_i,
  input logic                             flag_val_i,
  input logic                             exit_seg_i,
  input logic                             inc_inner_i,
  input logic                             dec_inner_i,
  input logic [NUM_FLAGS-1:0]             flags_o,
  input logic [NUM_STAGES-1:0][CNT_W-1:0] cur_arr,
  input logic [NUM_STAGES-1:0][CNT_W-1:0] init_arr,
  input logic [CNT_W-1:0]                 sel_cur,
  input logic [STG_W-1:0]                 wr_idx,
  input logic                             ev_clear,
  input logic                             ev_load,
  input logic                             ev_dec,
  input logic                             ev_adj_up,
  input logic                             ev_adj_dn,
  input logic                             ev_flag_wr
);

  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clear |=> (cur_arr == '0) && (init_arr == '0) && (flags_o == '0)); // R1

  AST_LOAD_BOTH_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load |=> cur_arr[$past(wr_idx)] == init_arr[$past(wr_idx)]); // R2

  AST_HOLD_MODE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dec && !dec_mode_i[1]) |=> $stable(cur_arr) && $stable(flags_o)); // R5

  AST_STEP_FIRST_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dec && dec_mode_i == 2'b11 && sel_cur == CNT_W'(1) && flag_sel_i != '0)
      |=> flags_o[$past(flag_sel_i) - FSEL_W'(1)] == $past(flag_val_i)); // R7

  AST_FLAGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_flag_wr && !ev_clear) |=> $stable(flags_o)); // R8

  AST_ADJ_KEEPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_adj_up || ev_adj_dn) |=> $stable(init_arr)); // R9

  AST_ADJ_OUTSIDE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((inc_inner_i || dec_inner_i) && !exit_seg_i && !start_i && !load_i && !dec_i)
      |=> $stable(cur_arr) && $stable(init_arr)); // R10

endmodule

bind nested_stage_counter nsc_checker #(
  .NUM_STAGES (NUM_STAGES),
  .CNT_W      (CNT_W),
  .NUM_FLAGS  (NUM_FLAGS),
  .STG_W      (STG_W),
  .FSEL_W     (FSEL_W)
) u_nsc_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .load_i      (load_i),
  .dec_i       (dec_i),
  .dec_mode_i  (dec_mode_i),
  .flag_sel_i  (flag_sel_i),
  .flag_val_i  (flag_val_i),
  .exit_seg_i  (exit_seg_i),
  .inc_inner_i (inc_inner_i),
  .dec_inner_i (dec_inner_i),
  .flags_o     (flags_o),
  .cur_arr     (cur_arr),
  .init_arr    (init_arr),
  .sel_cur     (sel_cur),
  .wr_idx      (wr_idx),
  .ev_clear    (ev_clear),
  .ev_load     (ev_load),
  .ev_dec      (ev_dec),
  .ev_adj_up   (ev_adj_up),
  .ev_adj_dn   (ev_adj_dn),
  .ev_flag_wr  (ev_flag_wr)
);

// File: tb/nested_stage_counter_bench.sv
`timescale 1ns/1ps
module nested_stage_counter_bench;

  localparam int NS = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] len_i = 16'd0;
  logic [4:0]  stage_i = 5'd0;
  logic        load_i = 1'b0;
  logic [1:0]  load_src_i = 2'b00;
  logic        dec_i = 1'b0;
  logic [1:0]  dec_mode_i = 2'b00;
  logic [2:0]  flag_sel_i = 3'd0;
  logic        flag_val_i = 1'b0;
  logic        exit_seg_i = 1'b0;
  logic        inc_inner_i = 1'b0;
  logic        dec_inner_i = 1'b0;
  logic [15:0] cur_o, init_o, inner_cur_o, inner_init_o;
  logic [6:0]  flags_o;

  nested_stage_counter u_nested_stage_counter (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .stage_i(stage_i), .load_i(load_i), .load_src_i(load_src_i),
    .dec_i(dec_i), .dec_mode_i(dec_mode_i), .flag_sel_i(flag_sel_i),
    .flag_val_i(flag_val_i), .exit_seg_i(exit_seg_i),
    .inc_inner_i(inc_inner_i), .dec_inner_i(dec_inner_i),
    .cur_o(cur_o), .init_o(init_o), .inner_cur_o(inner_cur_o),
    .inner_init_o(inner_init_o), .flags_o(flags_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [15:0] cur, ini, icur, iini;
    logic [6:0]  flg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [15:0] m_cur [0:NS+1];
  logic [15:0] m_ini [0:NS+1];
  logic [6:0]  m_flg;

  task automatic model_clear();
    for (int i = 0; i <= NS + 1; i++) begin
      m_cur[i] = 16'd0;
      m_ini[i] = 16'd0;
    end
    m_flg = 7'd0;
  endtask

  // Bench's own view of what the port readback must show.
  task automatic push_exp(input int s, input bit ex, input string tag);
    exp_t e;
    bool_ok : begin end
    e.cur = 16'd0; e.ini = 16'd0; e.icur = 16'd0; e.iini = 16'd0;
    if (s >= 1 && s <= NS) begin
      e.cur = m_cur[s];
      e.ini = m_ini[s];
      if (ex && s < NS) begin
        e.icur = m_cur[s + 1];
        e.iini = m_ini[s + 1];
      end
    end
    e.flg = m_flg;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Driver: applies one command, updates the model, queues the expectation.
  task automatic cmd(input bit st, input bit ld, input logic [1:0] src,
                     input bit dc, input logic [1:0] md, input logic [2:0] fs,
                     input bit fv, input bit ex, input bit up, input bit dn,
                     input int stg, input int obs, input bit obs_ex,
                     input string tag);
    logic [15:0] v;
    bit          z;
    @(negedge clk); #1;
    start_i = st; load_i = ld; load_src_i = src; dec_i = dc; dec_mode_i = md;
    flag_sel_i = fs; flag_val_i = fv; exit_seg_i = ex;
    inc_inner_i = up; dec_inner_i = dn; stage_i = 5'(stg);
    @(posedge clk); #2;
    if (st) model_clear();
    else if (stg >= 1 && stg <= NS) begin
      if (ld) begin
        if (src == 2'b11)      v = 16'd1;
        else if (src == 2'b00 || stg == 1) v = len_i;
        else if (src == 2'b01) v = m_ini[stg - 1];
        else                   v = m_cur[stg - 1];
        m_ini[stg] = v; m_cur[stg] = v;
      end else if (dc) begin
        z = 0;
        if (md == 2'b10) begin z = (m_cur[stg] == 0); m_cur[stg] = m_cur[stg] - 1; end
        if (md == 2'b11) begin m_cur[stg] = m_cur[stg] - 1; z = (m_cur[stg] == 0); end
        if (z && fs != 0) m_flg[fs - 1] = fv;
      end else if (ex && stg < NS && up != dn) begin
        m_cur[stg + 1] = up ? m_cur[stg + 1] + 1 : m_cur[stg + 1] - 1;
      end
    end
    start_i = 0; load_i = 0; dec_i = 0; inc_inner_i = 0; dec_inner_i = 0;
    flag_sel_i = 0; stage_i = 5'(obs); exit_seg_i = obs_ex;
    push_exp(obs, obs_ex, tag);
  endtask

  // Monitor: pops one expectation per falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_cmp++;
        if (cur_o !== e.cur || init_o !== e.ini || inner_cur_o !== e.icur ||
            inner_init_o !== e.iini || flags_o !== e.flg) begin
          n_bad++;
          $display("FAIL %s: got cur=%h ini=%h icur=%h iini=%h flg=%b exp cur=%h ini=%h icur=%h iini=%h flg=%b",
                   e.tag, cur_o, init_o, inner_cur_o, inner_init_o, flags_o,
                   e.cur, e.ini, e.icur, e.iini, e.flg);
        end
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    stage_i = 5'd1; exit_seg_i = 1'b1;
    push_exp(1, 1, "R1 reset state");
    @(negedge clk);
    len_i = 16'd5;
    // R2: length source
    cmd(0,1,2'b00,0,2'b00,0,0,0,0,0, 1, 1,0, "R2 load len");
    // R7 mode 11 no hit (5 -> 4)
    cmd(0,0,2'b00,1,2'b11,3'd1,1,0,0,0, 1, 1,0, "R7 step-first no hit");
    // R3 outer current / initial
    cmd(0,1,2'b10,0,2'b00,0,0,0,0,0, 2, 2,0, "R3 outer cur");
    cmd(0,1,2'b01,0,2'b00,0,0,0,0,0, 3, 3,0, "R3 outer init");
    // R4 constant one
    cmd(0,1,2'b11,0,2'b00,0,0,0,0,0, 3, 3,0, "R4 const one");
    // R7 + R8 hit: 1 -> 0, flag 2 := 1
    cmd(0,0,2'b00,1,2'b11,3'd2,1,0,0,0, 3, 3,0, "R7 R8 step-first hit");
    // R6 test-first hit with wrap: 0 -> FFFF, flag 3 := 1
    cmd(0,0,2'b00,1,2'b10,3'd3,1,0,0,0, 3, 3,0, "R6 test-first hit wrap");
    // R5 hold modes
    cmd(0,0,2'b00,1,2'b00,3'd4,1,0,0,0, 3, 3,0, "R5 mode 00");
    cmd(0,0,2'b00,1,2'b01,3'd4,1,0,0,0, 3, 3,0, "R5 mode 01");
    // R6 test-first no hit: 1 -> 0, flag 4 untouched
    cmd(0,1,2'b11,0,2'b00,0,0,0,0,0, 4, 4,0, "R4 load stage4");
    cmd(0,0,2'b00,1,2'b10,3'd4,1,0,0,0, 4, 4,0, "R6 test-first no hit");
    // R8 select 0 writes no flag; then clear flag 2
    cmd(0,1,2'b11,0,2'b00,0,0,0,0,0, 5, 5,0, "R4 load stage5");
    cmd(0,0,2'b00,1,2'b11,3'd0,1,0,0,0, 5, 5,0, "R8 select zero");
    cmd(0,1,2'b11,0,2'b00,0,0,0,0,0, 6, 6,0, "R4 load stage6");
    cmd(0,0,2'b00,1,2'b11,3'd2,0,0,0,0, 6, 6,0, "R8 write zero");
    // R9 / R11 inner adjust and readback from stage 1
    cmd(0,0,2'b00,0,2'b00,0,0,1,1,0, 1, 1,1, "R9 R11 inner inc");
    cmd(0,0,2'b00,0,2'b00,0,0,1,0,1, 1, 1,1, "R9 inner dec");
    cmd(0,0,2'b00,0,2'b00,0,0,1,0,1, 1, 1,1, "R9 inner dec again");
    cmd(0,0,2'b00,0,2'b00,0,0,1,1,1, 1, 1,1, "R9 both ignored");
    // R10 outside exit segment / deepest stage
    cmd(0,0,2'b00,0,2'b00,0,0,0,1,0, 1, 1,1, "R10 no exit seg");
    cmd(0,0,2'b00,0,2'b00,0,0,1,1,0, 31, 31,1, "R10 deepest stage");
    cmd(0,0,2'b00,0,2'b00,0,0,0,0,0, 2, 2,0, "R11 readback off");
    // R12 priority and invalid stage
    len_i = 16'd9;
    cmd(0,1,2'b00,1,2'b11,3'd5,1,1,1,0, 7, 7,1, "R12 load beats dec adj");
    cmd(0,0,2'b00,1,2'b11,3'd5,1,1,1,0, 7, 8,0, "R12 dec beats adj");
    cmd(0,1,2'b00,0,2'b00,0,0,0,0,0, 0, 0,1, "R12 stage zero");
    cmd(0,1,2'b00,0,2'b00,0,0,0,0,0, 0, 1,0, "R12 stage zero no write");
    // R13: no early effect before the accepting edge
    @(negedge clk); #1;
    stage_i = 5'd1; load_i = 1; load_src_i = 2'b11;
    #4;
    n_cmp++;
    if (cur_o !== m_cur[1]) begin
      n_bad++;
      $display("FAIL R13 early: got %h exp %h", cur_o, m_cur[1]);
    end
    @(posedge clk); #2;
    m_cur[1] = 16'd1; m_ini[1] = 16'd1; load_i = 0;
    push_exp(1, 0, "R13 after edge");
    // R3 stage 1 outer codes take length
    cmd(0,1,2'b10,0,2'b00,0,0,0,0,0, 1, 1,0, "R3 stage1 uses len");
    // R1 start clears
    cmd(1,1,2'b11,1,2'b11,3'd1,1,1,1,0, 7, 7,1, "R1 start clears");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule